// File: doc/BRIEF.md
# Synchronized Chirp Overlay Adder/Remover

This block sits in a complex baseband OFDM sample stream. It either places a short, fixed sensing chirp on top of every sample on the transmit side, or takes that same chirp back out on the receive side. One parameter chooses the direction at build time. The chirp is a DC-centred quadratic-phase sweep that is computed ahead of time and held in a small on-chip lookup. No oscillator or phase accumulator generates it at run time.

A sample counter selects the chirp entry for each sample. The OFDM pipeline supplies a slot-start pulse together with the first sample of each slot, and that pulse forces the counter back to the start of the chirp. The chirp length is chosen so that it divides the common period of the FFT size and both cyclic prefix lengths, which is 16 samples. As a result, the chirp tiles every symbol body many times over and starts at the same phase in every symbol. In each lane, I and Q, the sum or difference clips at the signed 16-bit limits. The block adds one register stage between its valid/ready input and output streams.

Top module: `chirp_overlay`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A sample is accepted on a clock edge where in_valid and in_ready are both 1. Its result appears on the output with out_valid high right after that edge, so the block has a latency of one cycle.
- R3: With SUBTRACT=0, out_re = sat(in_re + c.re) and out_im = sat(in_im + c.im), where c is the chirp entry selected for that sample.
- R4: With SUBTRACT=1, out_re = sat(in_re - c.re) and out_im = sat(in_im - c.im).
- R5: sat() clips to the range 32767 to -32768, and it does so for each lane on its own.
- R6: An accepted sample with in_mark=1 uses chirp entry 0. That sample then leaves the block with out_mark=1, and every unmarked sample leaves with out_mark=0.
- R7: The entry index goes up by one for each accepted sample and wraps from CHIRP_LEN-1 back to 0. An index value is used by exactly one accepted sample. Idle cycles and stalled cycles do not change it.
- R8: While out_valid=1 and out_ready=0, the output sample and out_mark stay unchanged, and in_ready is 0.
- R9: For a chirp of length L (1, 2, 4, 8 or 16), entry n is base entry n*16/L. Base entry m is round(4096·exp(jπ(m-8)²/16)), with I as the real part and Q as the imaginary part.
- R10: After reset, the entry index is 0 before any mark has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_re | input | 16 | Input I, signed |
| in_im | input | 16 | Input Q, signed |
| in_mark | input | 1 | Slot start, arrives with the first sample of a slot |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the sample |
| out_re | output | 16 | Output I, signed |
| out_im | output | 16 | Output Q, signed |
| out_mark | output | 1 | Slot start, moved along with its sample |

## Verification
The assertions check several properties on every cycle. An output that is stalled holds steady and blocks the input. An accepted sample becomes valid on the next cycle and keeps its mark. The entry counter stays in range and does not move on cycles where no sample is accepted. In each lane, the clipped result never wraps to the wrong sign. The bench scenarios are what show the arithmetic itself, namely the exact sums and differences against the chirp table. The same scenarios show that a mark realigns the index, that the index wraps at both chirp lengths, and that gaps and stalls leave the chirp phase where it was.

// File: rtl/chirp_overlay_pkg.sv
package chirp_overlay_pkg;

    localparam int CX_W     = 16;
    localparam int BASE_LEN = 16;

    typedef struct packed {
        logic signed [CX_W-1:0] re;
        logic signed [CX_W-1:0] im;
    } cx_t;

    // Base sweep: 4096 * exp(j*pi*(m-8)^2/16), rounded.
    function automatic cx_t chirp_base(input logic [3:0] m);
        cx_t v;
        case (m)
            4'd0, 4'd8:          v = '{re: 16'sd4096,  im: 16'sd0};
            4'd1, 4'd15:         v = '{re: -16'sd4017, im: -16'sd799};
            4'd2, 4'd6,
            4'd10, 4'd14:        v = '{re: 16'sd2896,  im: 16'sd2896};
            4'd3, 4'd13:         v = '{re: 16'sd799,   im: -16'sd4017};
            4'd4, 4'd12:         v = '{re: -16'sd4096, im: 16'sd0};
            4'd5, 4'd11:         v = '{re: -16'sd799,  im: 16'sd4017};
            default:             v = '{re: 16'sd4017,  im: 16'sd799};
        endcase
        return v;
    endfunction

endpackage

// File: rtl/chirp_phase_ctr.sv
module chirp_phase_ctr #(
    parameter int LEN   = 16,
    parameter int IDX_W = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             mark,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] cnt_d, cnt_q;

    always_comb begin
        idx   = mark ? '0 : cnt_q;
        cnt_d = cnt_q;
        if (adv) begin
            cnt_d = (idx == IDX_W'(LEN - 1)) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: the index stays inside the chirp
    a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < LEN);

    // R7: no movement without an accepted sample
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt_q));

endmodule

// File: rtl/chirp_rom.sv
module chirp_rom
    import chirp_overlay_pkg::*;
#(
    parameter int LEN   = 16,
    parameter int IDX_W = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic [IDX_W-1:0] idx,
    output cx_t              val
);

    localparam int STRIDE = BASE_LEN / LEN;

    logic [3:0] base_idx;

    generate
        if (LEN == 1) begin : g_single
            assign base_idx = 4'd0;
        end else begin : g_stride
            assign base_idx = 4'(32'(idx) * STRIDE);
        end
    endgenerate

    assign val = chirp_base(base_idx);

endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int W        = 16,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);

    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide;

    generate
        if (SUBTRACT) begin : g_sub
            assign wide = {a[W-1], a} - {b[W-1], b};
            // R5: differing signs never wrap to the sign of b
            always_comb begin
                if (a[W-1] != b[W-1])
                    a_r5_sub_no_wrap: assert (y[W-1] == a[W-1]);
            end
        end else begin : g_add
            assign wide = {a[W-1], a} + {b[W-1], b};
            // R5: matching signs never wrap
            always_comb begin
                if (a[W-1] == b[W-1])
                    a_r5_add_no_wrap: assert (y[W-1] == a[W-1]);
            end
        end
    endgenerate

    always_comb begin
        if (wide[W] == wide[W-1]) y = wide[W-1:0];
        else if (wide[W])         y = MINV;
        else                      y = MAXV;
    end

endmodule

// File: rtl/chirp_overlay.sv
module chirp_overlay
    import chirp_overlay_pkg::*;
#(
    parameter int CHIRP_LEN = 16,
    parameter bit SUBTRACT  = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic signed [CX_W-1:0] in_re,
    input  logic signed [CX_W-1:0] in_im,
    input  logic                   in_mark,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic signed [CX_W-1:0] out_re,
    output logic signed [CX_W-1:0] out_im,
    output logic                   out_mark
);

    localparam int IDX_W = (CHIRP_LEN > 1) ? $clog2(CHIRP_LEN) : 1;

    generate
        if (!(CHIRP_LEN == 1 || CHIRP_LEN == 2 || CHIRP_LEN == 4 ||
              CHIRP_LEN == 8 || CHIRP_LEN == 16)) begin : g_bad_len
            $error("CHIRP_LEN must be 1, 2, 4, 8 or 16");
        end
    endgenerate

    typedef struct packed {
        logic vld;
        logic mark;
        cx_t  data;
    } stage_t;

    stage_t           s_d, s_q;
    logic             accept;
    logic [IDX_W-1:0] idx;
    cx_t              chirp;
    cx_t              mixed;

    assign in_ready = !s_q.vld || out_ready;
    assign accept   = in_valid && in_ready;

    chirp_phase_ctr #(.LEN(CHIRP_LEN), .IDX_W(IDX_W)) i_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (accept),
        .mark  (in_mark),
        .idx   (idx)
    );

    chirp_rom #(.LEN(CHIRP_LEN), .IDX_W(IDX_W)) i_rom (
        .idx (idx),
        .val (chirp)
    );

    sat_addsub #(.W(CX_W), .SUBTRACT(SUBTRACT)) i_sat_re (
        .a (in_re),
        .b (chirp.re),
        .y (mixed.re)
    );

    sat_addsub #(.W(CX_W), .SUBTRACT(SUBTRACT)) i_sat_im (
        .a (in_im),
        .b (chirp.im),
        .y (mixed.im)
    );

    always_comb begin
        s_d = s_q;
        if (accept) begin
            s_d.vld  = 1'b1;
            s_d.mark = in_mark;
            s_d.data = mixed;
        end else if (out_ready) begin
            s_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_mark  = s_q.mark;
    assign out_re    = s_q.data.re;
    assign out_im    = s_q.data.im;

    // R2: accepted sample is presented on the next cycle
    a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R6: the mark travels with its sample
    a_r6_mark_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_mark == $past(in_mark)));

    // R8: stalled output holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_mark)));

    // R8: stalled output blocks the input
    a_r8_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/test_chirp_overlay.sv
`timescale 1ns/1ps
module test_chirp_overlay;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic               in_valid [2];
    logic               in_ready [2];
    logic               in_mark  [2];
    logic               out_valid[2];
    logic               out_ready[2];
    logic               out_mark [2];
    logic signed [15:0] in_re [2];
    logic signed [15:0] in_im [2];
    logic signed [15:0] out_re[2];
    logic signed [15:0] out_im[2];

    chirp_overlay #(.CHIRP_LEN(16), .SUBTRACT(1'b0)) i_chirp_overlay (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid[0]), .in_ready(in_ready[0]),
        .in_re(in_re[0]), .in_im(in_im[0]), .in_mark(in_mark[0]),
        .out_valid(out_valid[0]), .out_ready(out_ready[0]),
        .out_re(out_re[0]), .out_im(out_im[0]), .out_mark(out_mark[0])
    );

    chirp_overlay #(.CHIRP_LEN(4), .SUBTRACT(1'b1)) i_chirp_overlay_rx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid[1]), .in_ready(in_ready[1]),
        .in_re(in_re[1]), .in_im(in_im[1]), .in_mark(in_mark[1]),
        .out_valid(out_valid[1]), .out_ready(out_ready[1]),
        .out_re(out_re[1]), .out_im(out_im[1]), .out_mark(out_mark[1])
    );

    int total = 0;
    int bad   = 0;
    int cnt_model[2];
    logic [32:0] exp_q0[$];
    logic [32:0] exp_q1[$];
    string       tag_q0[$];
    string       tag_q1[$];

    // R9 base table, I part
    function automatic int ref_re(input int m);
        case (m)
            0, 8:           return 4096;
            1, 15:          return -4017;
            2, 6, 10, 14:   return 2896;
            3, 13:          return 799;
            4, 12:          return -4096;
            5, 11:          return -799;
            default:        return 4017;
        endcase
    endfunction

    // R9 base table, Q part
    function automatic int ref_im(input int m);
        case (m)
            0, 8, 4, 12:    return 0;
            1, 15:          return -799;
            2, 6, 10, 14:   return 2896;
            3, 13:          return -4017;
            5, 11:          return 4017;
            default:        return 799;
        endcase
    endfunction

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic send(input int k, input int re, input int im,
                        input bit mark, input string tag);
        int len;
        int idx;
        int cre;
        int cim;
        int yre;
        int yim;
        logic [32:0] e;
        len = (k == 0) ? 16 : 4;
        in_valid[k] = 1'b1;
        in_re[k]    = 16'(re);
        in_im[k]    = 16'(im);
        in_mark[k]  = mark;
        @(negedge clk);
        while (!in_ready[k]) @(negedge clk);
        idx = mark ? 0 : cnt_model[k];
        cnt_model[k] = (idx + 1) % len;
        cre = ref_re(idx * (16 / len));
        cim = ref_im(idx * (16 / len));
        if (k == 0) begin
            yre = sat16(re + cre);
            yim = sat16(im + cim);
        end else begin
            yre = sat16(re - cre);
            yim = sat16(im - cim);
        end
        e = {mark, 16'(yre), 16'(yim)};
        if (k == 0) begin exp_q0.push_back(e); tag_q0.push_back(tag); end
        else        begin exp_q1.push_back(e); tag_q1.push_back(tag); end
        @(posedge clk);
        #1;
        in_valid[k] = 1'b0;
        in_mark[k]  = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst_n && out_valid[k] && out_ready[k]) begin
                logic [32:0] e;
                string t;
                if ((k == 0 && exp_q0.size() == 0) || (k == 1 && exp_q1.size() == 0)) begin
                    chk(1'b0, "R2", "unexpected output", 1, 0);
                end else begin
                    if (k == 0) begin e = exp_q0.pop_front(); t = tag_q0.pop_front(); end
                    else        begin e = exp_q1.pop_front(); t = tag_q1.pop_front(); end
                    chk(out_re[k] == $signed(e[31:16]), t, "re", out_re[k], $signed(e[31:16]));
                    chk(out_im[k] == $signed(e[15:0]),  t, "im", out_im[k], $signed(e[15:0]));
                    chk(out_mark[k] == e[32], "R6", "mark", out_mark[k], e[32]);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic signed [15:0] cap_re;
        for (int k = 0; k < 2; k++) begin
            in_valid[k] = 0; in_mark[k] = 0; in_re[k] = 0; in_im[k] = 0;
            out_ready[k] = 1; cnt_model[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(out_valid[k] == 0, "R1", "out_valid after reset", out_valid[k], 0);
            chk(in_ready[k] == 1,  "R1", "in_ready after reset",  in_ready[k], 1);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R10 and R2: first sample without mark uses entry 0, one cycle later
        send(0, 100, -200, 1'b0, "R10");
        chk(out_valid[0] == 1, "R2", "valid one cycle after accept", out_valid[0], 1);
        send(1, 300, 400, 1'b0, "R10");
        chk(out_valid[1] == 1, "R2", "valid one cycle after accept", out_valid[1], 1);

        // R3: add mode stream across a wrap, with a mark mid-stream (R6)
        for (int n = 0; n < 20; n++)
            send(0, n * 37 - 300, 500 - n * 53, (n == 7), "R3");
        for (int n = 0; n < 20; n++)
            send(0, -n * 1000, n * 900, (n == 0), "R3");

        // R4: subtract mode, length-4 chirp, marks realign (R6, R9)
        for (int n = 0; n < 14; n++)
            send(1, n * 211 - 1000, 2000 - n * 97, (n == 5 || n == 9), "R4");

        // R5: clipping per lane
        send(0, 32000, -32000, 1'b1, "R5");
        send(0, 32000, -32500, 1'b0, "R5");
        send(0, -32768, 32767, 1'b0, "R5");
        send(1, -30000, 10, 1'b1, "R5");
        send(1, 30000, -32768, 1'b0, "R5");

        // R7: idle gaps do not advance the index
        for (int n = 0; n < 6; n++) begin
            send(0, 1000 + n, 2000 - n, 1'b0, "R7");
            repeat (n % 3 + 1) @(posedge clk);
            #1;
            send(1, 1000 + n, 2000 - n, 1'b0, "R7");
            repeat (2) @(posedge clk);
            #1;
        end

        // R8: stall holds output and blocks input
        repeat (3) @(posedge clk);
        #1;
        out_ready[0] = 1'b0;
        send(0, 4321, -1234, 1'b0, "R8");
        @(negedge clk);
        cap_re = out_re[0];
        fork
            send(0, 555, 666, 1'b0, "R7");
        join_none
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(in_ready[0] == 0,      "R8", "in_ready while stalled", in_ready[0], 0);
            chk(out_valid[0] == 1,     "R8", "valid held",            out_valid[0], 1);
            chk(out_re[0] == cap_re,   "R8", "data held",             out_re[0], cap_re);
        end
        @(posedge clk); #1;
        out_ready[0] = 1'b1;
        wait fork;
        send(0, 7, 8, 1'b0, "R7");

        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(exp_q0.size() == 0, "R2", "tx queue drained", exp_q0.size(), 0);
        chk(exp_q1.size() == 0, "R2", "rx queue drained", exp_q1.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule